// File: doc/BRIEF.md
# Extend and Logic Execution Unit

This block executes a small family of 32-bit register operations in a single clock: sign and zero extension of the low byte or low halfword of a register, XOR of two registers, XOR of a register with a 16-bit immediate, and a logical test. The test ANDs two registers and keeps only the condition flags. The unit decodes a 16-bit instruction halfword, plus an immediate halfword when the operation needs one. It reads its operands from a 32-entry register file, writes the result back and updates a four-bit condition-flag register.

The surrounding logic presents an instruction with `issue_valid`. The result appears on a registered write-back port one clock later, together with the updated flags. A load port preloads register contents and a second load port preloads the flags. A registered read port lets any register be observed. There is no fetch logic and no pipelining.

Flag bits on `flags_o` and `flag_ld_val` are ordered {CY, OV, S, Z}: CY is bit 3, OV bit 2, S bit 1 and Z bit 0.

Top module: `xlu_top`

## Requirements
- R1: Halfword 0x00A0|n (bits 15:5 = 00000000101) replaces register n with its bits 7:0 sign-extended to 32 bits. Halfword 0x00E0|n (bits 15:5 = 00000000111) replaces register n with its bits 15:0 sign-extended.
- R2: Halfword 0x0080|n replaces register n with its bits 7:0 zero-extended. Halfword 0x00C0|n replaces register n with its bits 15:0 zero-extended.
- R3: The four extend operations leave all four flags unchanged.
- R4: A halfword whose bits 10:5 are 001001 writes rB XOR rA into rB. rB is the register named in bits 15:11 and rA the register named in bits 4:0.
- R5: A halfword whose bits 10:5 are 110101 takes `imm_hw` as a zero-extended 16-bit immediate and writes rA XOR that immediate into rB.
- R6: A halfword whose bits 10:5 are 001011 computes rB AND rA and writes no register.
- R7: XOR, immediate XOR and test keep CY and clear OV. They set S to bit 31 of the result, and set Z when all 32 result bits are zero.
- R8: Register 0 always reads as zero. Any write to it, from an operation or from the load port, is discarded, and `wb_valid` stays low for it. Flags still update.
- R9: With `issue_valid` low, or with a halfword that matches none of the encodings above, no register, no flag and no write-back output changes.
- R10: The write-back port (`wb_valid`, `wb_idx`, `wb_data`) and the flags show an operation's effect on the first clock edge after issue. `rd_data` shows register `rd_idx` one clock after `rd_idx` is presented.
- R11: After a synchronous reset, `flags_o` is 0000 and `wb_valid` is low.
- R12: `reg_ld_en` writes `reg_ld_data` into register `reg_ld_idx`. `flag_ld_en` loads `flag_ld_val` into the flags. When an issued operation writes a register or the flags in the same clock, the operation wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Execute the presented instruction this cycle |
| instr_hw | input | 16 | Instruction halfword |
| imm_hw | input | 16 | Immediate halfword for immediate XOR |
| reg_ld_en | input | 1 | Register preload strobe |
| reg_ld_idx | input | 5 | Register preload index |
| reg_ld_data | input | 32 | Register preload value |
| flag_ld_en | input | 1 | Flag preload strobe |
| flag_ld_val | input | 4 | Flag preload value {CY,OV,S,Z} |
| rd_idx | input | 5 | Observation read index |
| rd_data | output | 32 | Registered read data |
| flags_o | output | 4 | Condition flags {CY,OV,S,Z} |
| wb_valid | output | 1 | A register was written by the last operation |
| wb_idx | output | 5 | Destination register of the last write |
| wb_data | output | 32 | Value written |

## Verification
Several rules are checked on every cycle by properties that use only the ports. Extends never move the flags. The logic operations keep CY and clear OV, and their S and Z agree with the written value. The test and idle cycles never raise `wb_valid`, and register 0 never appears as a write-back destination. The exact extended and XOR values, the zero-extension of the immediate, the discard of writes to register 0, operation-over-load priority and the read-back of stored registers depend on register contents, so only the bench's vectors and directed scenarios can show them.

// File: rtl/xlu_pkg.sv
package xlu_pkg;

  localparam int INSTR_W   = 16;
  localparam int IMM_W     = 16;
  localparam int REG_IDX_W = 5;
  localparam int REG_CNT   = 1 << REG_IDX_W;
  localparam int FLAG_W    = 4;

  // flag bit positions inside the flag vector
  localparam int FL_CY = 3;
  localparam int FL_OV = 2;
  localparam int FL_S  = 1;
  localparam int FL_Z  = 0;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_SXB,
    OP_SXH,
    OP_ZXB,
    OP_ZXH,
    OP_XOR,
    OP_XORI,
    OP_TST
  } xlu_op_e;

  typedef struct packed {
    xlu_op_e                op;
    logic [REG_IDX_W-1:0]   src_a;
    logic [REG_IDX_W-1:0]   src_b;
    logic [REG_IDX_W-1:0]   dst;
    logic                   wr;
    logic                   upd_flags;
  } xlu_dec_t;

endpackage

// File: rtl/xlu_decode.sv
module xlu_decode
  import xlu_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output xlu_dec_t           dec
);

  logic [REG_IDX_W-1:0] fld_lo;
  logic [REG_IDX_W-1:0] fld_hi;
  logic                 ext_grp;
  logic [5:0]           sub;

  assign fld_lo  = instr[4:0];
  assign fld_hi  = instr[15:11];
  assign sub     = instr[10:5];
  assign ext_grp = (instr[15:7] == 9'b0_0000_0001);

  always_comb begin
    dec           = '0;
    dec.op        = OP_NONE;
    dec.src_a     = fld_lo;
    dec.src_b     = fld_hi;
    dec.dst       = fld_hi;
    if (ext_grp) begin
      dec.dst = fld_lo;
      unique case (instr[6:5])
        2'b00: dec.op = OP_ZXB;
        2'b01: dec.op = OP_SXB;
        2'b10: dec.op = OP_ZXH;
        default: dec.op = OP_SXH;
      endcase
    end else begin
      case (sub)
        6'b001001: dec.op = OP_XOR;
        6'b110101: dec.op = OP_XORI;
        6'b001011: dec.op = OP_TST;
        default:   dec.op = OP_NONE;
      endcase
    end
    dec.upd_flags = (dec.op == OP_XOR) || (dec.op == OP_XORI) || (dec.op == OP_TST);
    dec.wr        = (dec.op != OP_NONE) && (dec.op != OP_TST) && (dec.dst != '0);
  end

endmodule

// File: rtl/xlu_regfile.sv
module xlu_regfile #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [$clog2(DEPTH)-1:0] ra_idx,
  output logic [DATA_W-1:0]        ra_data,
  input  logic [$clog2(DEPTH)-1:0] rb_idx,
  output logic [DATA_W-1:0]        rb_data,
  input  logic [$clog2(DEPTH)-1:0] rc_idx,
  output logic [DATA_W-1:0]        rc_data
);

  localparam int AW = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && (waddr != AW'(0))) begin
      mem[waddr] <= wdata;
    end
  end

  // entry 0 is hardwired to zero on every read port
  assign ra_data = (ra_idx == AW'(0)) ? '0 : mem[ra_idx];
  assign rb_data = (rb_idx == AW'(0)) ? '0 : mem[rb_idx];

  always_ff @(posedge clk) begin
    rc_data <= (rc_idx == AW'(0)) ? '0 : mem[rc_idx];
  end

endmodule

// File: rtl/xlu_alu.sv
module xlu_alu
  import xlu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  xlu_op_e           op,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [IMM_W-1:0]  imm,
  input  logic [FLAG_W-1:0] flags_in,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] flags_out
);

  localparam int PAD_B = DATA_W - 8;
  localparam int PAD_H = DATA_W - 16;

  logic is_logic;

  always_comb begin
    unique case (op)
      OP_SXB:  result = {{PAD_B{opa[7]}},  opa[7:0]};
      OP_SXH:  result = {{PAD_H{opa[15]}}, opa[15:0]};
      OP_ZXB:  result = {{PAD_B{1'b0}},    opa[7:0]};
      OP_ZXH:  result = {{PAD_H{1'b0}},    opa[15:0]};
      OP_XOR:  result = opb ^ opa;
      OP_XORI: result = opa ^ {{(DATA_W-IMM_W){1'b0}}, imm};
      OP_TST:  result = opb & opa;
      default: result = '0;
    endcase
  end

  assign is_logic = (op == OP_XOR) || (op == OP_XORI) || (op == OP_TST);

  always_comb begin
    flags_out = flags_in;
    if (is_logic) begin
      flags_out[FL_OV] = 1'b0;
      flags_out[FL_S]  = result[DATA_W-1];
      flags_out[FL_Z]  = (result == '0);
    end
  end

endmodule

// File: rtl/xlu_top.sv
module xlu_top
  import xlu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 issue_valid,
  input  logic [INSTR_W-1:0]   instr_hw,
  input  logic [IMM_W-1:0]     imm_hw,
  input  logic                 reg_ld_en,
  input  logic [REG_IDX_W-1:0] reg_ld_idx,
  input  logic [DATA_W-1:0]    reg_ld_data,
  input  logic                 flag_ld_en,
  input  logic [FLAG_W-1:0]    flag_ld_val,
  input  logic [REG_IDX_W-1:0] rd_idx,
  output logic [DATA_W-1:0]    rd_data,
  output logic [FLAG_W-1:0]    flags_o,
  output logic                 wb_valid,
  output logic [REG_IDX_W-1:0] wb_idx,
  output logic [DATA_W-1:0]    wb_data
);

  xlu_dec_t             dec;
  logic [DATA_W-1:0]    opa;
  logic [DATA_W-1:0]    opb;
  logic [DATA_W-1:0]    alu_res;
  logic [FLAG_W-1:0]    alu_flags;
  logic [FLAG_W-1:0]    flags_q;
  logic                 exec;
  logic                 do_wr;
  logic                 rf_we;
  logic [REG_IDX_W-1:0] rf_waddr;
  logic [DATA_W-1:0]    rf_wdata;
  logic                 wb_valid_q;
  logic [REG_IDX_W-1:0] wb_idx_q;
  logic [DATA_W-1:0]    wb_data_q;

  xlu_decode u_dec (
    .instr (instr_hw),
    .dec   (dec)
  );

  assign exec  = issue_valid && (dec.op != OP_NONE);
  assign do_wr = exec && dec.wr;

  // an executing operation takes the write port ahead of the preload port
  assign rf_we    = do_wr || reg_ld_en;
  assign rf_waddr = do_wr ? dec.dst : reg_ld_idx;
  assign rf_wdata = do_wr ? alu_res : reg_ld_data;

  xlu_regfile #(
    .DATA_W (DATA_W),
    .DEPTH  (REG_CNT)
  ) u_rf (
    .clk     (clk),
    .we      (rf_we),
    .waddr   (rf_waddr),
    .wdata   (rf_wdata),
    .ra_idx  (dec.src_a),
    .ra_data (opa),
    .rb_idx  (dec.src_b),
    .rb_data (opb),
    .rc_idx  (rd_idx),
    .rc_data (rd_data)
  );

  xlu_alu #(
    .DATA_W (DATA_W)
  ) u_alu (
    .op        (dec.op),
    .opa       (opa),
    .opb       (opb),
    .imm       (imm_hw),
    .flags_in  (flags_q),
    .result    (alu_res),
    .flags_out (alu_flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q    <= '0;
      wb_valid_q <= 1'b0;
      wb_idx_q   <= '0;
      wb_data_q  <= '0;
    end else begin
      wb_valid_q <= do_wr;
      if (do_wr) begin
        wb_idx_q  <= dec.dst;
        wb_data_q <= alu_res;
      end
      if (exec && dec.upd_flags) begin
        flags_q <= alu_flags;
      end else if (flag_ld_en) begin
        flags_q <= flag_ld_val;
      end
    end
  end

  assign flags_o  = flags_q;
  assign wb_valid = wb_valid_q;
  assign wb_idx   = wb_idx_q;
  assign wb_data  = wb_data_q;

endmodule

// File: rtl/xlu_checker.sv
module xlu_checker
  import xlu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 issue_valid,
  input logic [INSTR_W-1:0]   instr_hw,
  input logic                 flag_ld_en,
  input logic [FLAG_W-1:0]    flags_o,
  input logic                 wb_valid,
  input logic [REG_IDX_W-1:0] wb_idx,
  input logic [DATA_W-1:0]    wb_data
);

  logic ext_iss;
  logic logic_iss;
  logic tst_iss;

  assign ext_iss   = issue_valid && (instr_hw[15:7] == 9'b0_0000_0001);
  assign tst_iss   = issue_valid && (instr_hw[10:5] == 6'b001011) && !(instr_hw[15:7] == 9'b0_0000_0001);
  assign logic_iss = issue_valid && !(instr_hw[15:7] == 9'b0_0000_0001) &&
                     ((instr_hw[10:5] == 6'b001001) || (instr_hw[10:5] == 6'b110101) ||
                      (instr_hw[10:5] == 6'b001011));

  // R3: extends never move any flag
  a_r3_ext_flags_hold: assert property (@(posedge clk) disable iff (rst)
    ext_iss |=> $stable(flags_o));

  // R7: logic ops keep CY and clear OV
  a_r7_cy_kept_ov_clear: assert property (@(posedge clk) disable iff (rst)
    logic_iss |=> (flags_o[FL_CY] == $past(flags_o[FL_CY])) && !flags_o[FL_OV]);

  // R7: S and Z agree with the written value
  a_r7_sz_match: assert property (@(posedge clk) disable iff (rst)
    logic_iss |=> (!wb_valid ||
                   ((flags_o[FL_S] == wb_data[DATA_W-1]) && (flags_o[FL_Z] == (wb_data == '0)))));

  // R6: test writes no register
  a_r6_tst_no_wb: assert property (@(posedge clk) disable iff (rst)
    tst_iss |=> !wb_valid);

  // R8: register 0 is never a write-back destination
  a_r8_no_r0_wb: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> (wb_idx != '0));

  // R9: idle cycles change neither flags nor write-back
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (!issue_valid && !flag_ld_en) |=> (!wb_valid && $stable(flags_o)));

endmodule

bind xlu_top xlu_checker #(.DATA_W(DATA_W)) u_xlu_chk (
  .clk         (clk),
  .rst         (rst),
  .issue_valid (issue_valid),
  .instr_hw    (instr_hw),
  .flag_ld_en  (flag_ld_en),
  .flags_o     (flags_o),
  .wb_valid    (wb_valid),
  .wb_idx      (wb_idx),
  .wb_data     (wb_data)
);

// File: tb/xlu_top_tb_top.sv
`timescale 1ns/1ps
module xlu_top_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue_valid = 1'b0;
  logic [15:0] instr_hw = '0;
  logic [15:0] imm_hw = '0;
  logic        reg_ld_en = 1'b0;
  logic [4:0]  reg_ld_idx = '0;
  logic [31:0] reg_ld_data = '0;
  logic        flag_ld_en = 1'b0;
  logic [3:0]  flag_ld_val = '0;
  logic [4:0]  rd_idx = '0;
  logic [31:0] rd_data;
  logic [3:0]  flags_o;
  logic        wb_valid;
  logic [4:0]  wb_idx;
  logic [31:0] wb_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  xlu_top dut_i (
    .clk         (clk),
    .rst         (rst),
    .issue_valid (issue_valid),
    .instr_hw    (instr_hw),
    .imm_hw      (imm_hw),
    .reg_ld_en   (reg_ld_en),
    .reg_ld_idx  (reg_ld_idx),
    .reg_ld_data (reg_ld_data),
    .flag_ld_en  (flag_ld_en),
    .flag_ld_val (flag_ld_val),
    .rd_idx      (rd_idx),
    .rd_data     (rd_data),
    .flags_o     (flags_o),
    .wb_valid    (wb_valid),
    .wb_idx      (wb_idx),
    .wb_data     (wb_data)
  );

  typedef struct packed {
    logic [15:0] instr;
    logic [15:0] imm;
    logic [31:0] a_val;
    logic [31:0] b_val;
    logic [3:0]  fl_in;
    logic        exp_wr;
    logic [31:0] exp_val;
    logic [3:0]  fl_out;
  } vec_t;

  localparam int NVEC = 13;
  // flags are {CY,OV,S,Z}
  localparam vec_t VECS [NVEC] = '{
    '{16'h00A3, 16'h0000, 32'h12345680, 32'h0,        4'b1111, 1'b1, 32'hFFFFFF80, 4'b1111},
    '{16'h00A3, 16'h0000, 32'hFFFFFF7F, 32'h0,        4'b0000, 1'b1, 32'h0000007F, 4'b0000},
    '{16'h00E4, 16'h0000, 32'h00008001, 32'h0,        4'b1010, 1'b1, 32'hFFFF8001, 4'b1010},
    '{16'h00E4, 16'h0000, 32'h80007FFF, 32'h0,        4'b0101, 1'b1, 32'h00007FFF, 4'b0101},
    '{16'h0085, 16'h0000, 32'hDEADBEEF, 32'h0,        4'b0110, 1'b1, 32'h000000EF, 4'b0110},
    '{16'h00C6, 16'h0000, 32'hDEADBEEF, 32'h0,        4'b1001, 1'b1, 32'h0000BEEF, 4'b1001},
    '{16'h1121, 16'h0000, 32'hF0F00000, 32'h0F0F0000, 4'b1100, 1'b1, 32'hFFFF0000, 4'b1010},
    '{16'h1121, 16'h0000, 32'h12345678, 32'h12345678, 4'b0110, 1'b1, 32'h00000000, 4'b0001},
    '{16'h1121, 16'h0000, 32'h00000001, 32'h00000003, 4'b1001, 1'b1, 32'h00000002, 4'b1000},
    '{16'h46A7, 16'h8001, 32'h80000000, 32'h00000000, 4'b0100, 1'b1, 32'h80008001, 4'b0010},
    '{16'h46A7, 16'hFFFF, 32'h0000FFFF, 32'h12121212, 4'b1000, 1'b1, 32'h00000000, 4'b1001},
    '{16'h5169, 16'h0000, 32'h800000F0, 32'h8000000F, 4'b0101, 1'b0, 32'h8000000F, 4'b0010},
    '{16'h5169, 16'h0000, 32'h000000F0, 32'h0000000F, 4'b1000, 1'b0, 32'h0000000F, 4'b1001}
  };

  function automatic string tag_of(input int k);
    if (k < 4)  return "R1";
    if (k < 6)  return "R2";
    if (k < 9)  return "R4";
    if (k < 11) return "R5";
    return "R6";
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic load_reg(input logic [4:0] idx, input logic [31:0] val);
    @(negedge clk);
    reg_ld_en = 1'b1; reg_ld_idx = idx; reg_ld_data = val;
    @(negedge clk);
    reg_ld_en = 1'b0;
  endtask

  task automatic load_flags(input logic [3:0] val);
    @(negedge clk);
    flag_ld_en = 1'b1; flag_ld_val = val;
    @(negedge clk);
    flag_ld_en = 1'b0;
  endtask

  // presents one instruction for one cycle; returns at the sample point after the edge
  task automatic issue(input logic v, input logic [15:0] ins, input logic [15:0] imm);
    @(negedge clk);
    issue_valid = v; instr_hw = ins; imm_hw = imm;
    @(negedge clk);
    issue_valid = 1'b0;
  endtask

  task automatic read_reg(input logic [4:0] idx, output logic [31:0] val);
    @(negedge clk);
    rd_idx = idx;
    @(negedge clk);
    val = rd_data;
  endtask

  task automatic run_vec(input int k);
    vec_t        v;
    logic [4:0]  fa;
    logic [4:0]  fb;
    logic [4:0]  dst;
    logic        ext;
    logic [31:0] rb;
    v   = VECS[k];
    fa  = v.instr[4:0];
    fb  = v.instr[15:11];
    ext = (v.instr[15:8] == 8'h00);
    dst = ext ? fa : fb;
    load_reg(fa, v.a_val);
    if (!ext) load_reg(fb, v.b_val);
    load_flags(v.fl_in);
    issue(1'b1, v.instr, v.imm);
    check({tag_of(k), " R10 wb_valid"}, {31'b0, wb_valid}, {31'b0, v.exp_wr});
    if (v.exp_wr) begin
      check({tag_of(k), " wb_data"}, wb_data, v.exp_val);
      check({tag_of(k), " wb_idx"}, {27'b0, wb_idx}, {27'b0, dst});
    end
    check(ext ? "R3 flags" : "R7 flags", {28'b0, flags_o}, {28'b0, v.fl_out});
    read_reg(dst, rb);
    check({tag_of(k), " readback"}, rb, v.exp_val);
  endtask

  initial begin
    logic [31:0] rv;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    check("R11 flags after reset", {28'b0, flags_o}, 32'h0);
    check("R11 wb_valid after reset", {31'b0, wb_valid}, 32'h0);

    // R12: preload ports
    load_reg(5'd12, 32'hCAFE0001);
    read_reg(5'd12, rv);
    check("R12 reg preload", rv, 32'hCAFE0001);
    load_flags(4'b1011);
    check("R12 flag preload", {28'b0, flags_o}, 32'hB);

    for (int k = 0; k < NVEC; k++) run_vec(k);

    // R8: register 0 reads zero, load to it discarded
    load_reg(5'd0, 32'h0000FFFF);
    read_reg(5'd0, rv);
    check("R8 r0 after load", rv, 32'h0);
    // R8: XOR into r0 discarded, flags still update
    load_reg(5'd1, 32'h00000005);
    load_flags(4'b0001);
    issue(1'b1, 16'h0121, 16'h0);
    check("R8 wb_valid for r0", {31'b0, wb_valid}, 32'h0);
    check("R8 flags for r0 dest", {28'b0, flags_o}, 32'h0);
    read_reg(5'd0, rv);
    check("R8 r0 after xor", rv, 32'h0);
    // R8: r0 as source reads zero
    load_reg(5'd2, 32'h80000000);
    load_flags(4'b0000);
    issue(1'b1, 16'h1120, 16'h0);
    check("R8 r0 source wb_data", wb_data, 32'h80000000);
    check("R8 r0 source flags", {28'b0, flags_o}, 32'h2);

    // R9: unrecognized halfword
    load_reg(5'd31, 32'h0000AAAA);
    load_flags(4'b1011);
    issue(1'b1, 16'hFFFF, 16'h1234);
    check("R9 unknown wb_valid", {31'b0, wb_valid}, 32'h0);
    check("R9 unknown flags", {28'b0, flags_o}, 32'hB);
    read_reg(5'd31, rv);
    check("R9 unknown r31", rv, 32'h0000AAAA);
    // R9: valid XOR r1->r31 presented with issue_valid low
    issue(1'b0, 16'hF921, 16'h0);
    check("R9 idle wb_valid", {31'b0, wb_valid}, 32'h0);
    check("R9 idle flags", {28'b0, flags_o}, 32'hB);
    read_reg(5'd31, rv);
    check("R9 idle r31", rv, 32'h0000AAAA);

    // R12: operation beats simultaneous preloads
    load_reg(5'd1, 32'h00000001);
    load_reg(5'd2, 32'h00000003);
    load_flags(4'b0000);
    @(negedge clk);
    issue_valid = 1'b1; instr_hw = 16'h1121;
    reg_ld_en = 1'b1; reg_ld_idx = 5'd2; reg_ld_data = 32'h0000DEAD;
    flag_ld_en = 1'b1; flag_ld_val = 4'b1111;
    @(negedge clk);
    issue_valid = 1'b0; reg_ld_en = 1'b0; flag_ld_en = 1'b0;
    check("R12 priority flags", {28'b0, flags_o}, 32'h0);
    read_reg(5'd2, rv);
    check("R12 priority reg", rv, 32'h00000002);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule